// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line of a small direct-mapped private cache attached to a shared snooping bus. Each line holds one data word, a tag and one of four states: Modified, Exclusive, Shared or Invalid. Processor reads and writes are served locally whenever the state allows. Otherwise the controller raises a single bus transaction and holds the processor off until the transaction completes. Transactions seen on the bus from other caches are snooped every cycle. The controller answers a snooped read with a shared-line indication and, for a dirty line, a writeback command that carries the line data.

A read miss fills the line as Shared or as Exclusive. The choice depends on the wired shared-line level that the other caches drive during the completing bus cycle. A later write to an Exclusive line becomes Modified with no bus traffic. A miss on an index that holds a dirty line of another tag first writes that victim back to memory and then fetches the new line. Clean victims are overwritten without any bus traffic. The arbiter, the memory and the other caches live outside the block.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid. busReq and cpuReady are low, and snoops produce neither snpHit nor snpWb.
- R2: A read whose tag misses (or whose line is Invalid) raises busReq with busCmd 0 (read) and busAddr equal to cpuAddr. At busAck the line fills with busRdata. It fills as Shared when busShared is high and as Exclusive when busShared is low, and the read then returns that data.
- R3: A read that hits a Shared, Exclusive or Modified line raises cpuReady in the same cycle with the stored word. It causes no bus transaction and no state change.
- R4: A write to a Shared line, or to a line that misses, issues busCmd 1 (read-exclusive) for cpuAddr. After busAck the line is Modified and holds the written word.
- R5: A write that hits an Exclusive line makes it Modified with no bus transaction. A write that hits a Modified line only updates the data. In both cases cpuReady rises in the request cycle.
- R6: A snooped bus read (snpCmd 0) that hits a Modified line raises snpWb with the line data on snpWbData and raises snpHit. The line ends Shared.
- R7: A snooped bus read that hits an Exclusive or Shared line raises snpHit without snpWb. The line ends Shared.
- R8: A snooped read-exclusive (snpCmd 1) never raises snpHit. It raises snpWb with the data for a Modified line. Any valid matching line ends Invalid.
- R9: A snoop whose tag differs from the stored tag, or whose line is Invalid, gives no snpHit, no snpWb and no state change.
- R10: A miss on an index that holds a Modified line of another tag first issues busCmd 2 (writeback) with the old tag's address and data, and only then fetches. A clean victim is replaced with no writeback.
- R11: At most one bus transaction is in flight. busReq stays high with a stable command and address until busAck, and cpuReady is never high while busReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | Request is a write (1) or read (0) |
| cpuAddr | input | ADDR_W | Request word address (low INDEX_W bits select the line) |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | 0 read, 1 read-exclusive, 2 writeback |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Writeback data |
| busAck | input | 1 | Transaction completes this cycle |
| busRdata | input | DATA_W | Fill data, valid with busAck |
| busShared | input | 1 | Wired shared-line level from other caches, valid with busAck |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 1 | 0 bus read, 1 bus read-exclusive |
| snpAddr | input | ADDR_W | Snooped address |
| snpHit | output | 1 | Shared-line response to a snooped read |
| snpWb | output | 1 | Writeback command for a dirty matching line |
| snpWbData | output | DATA_W | Data written back with snpWb |

## Verification
The assertions take the bus to be owned by this cache while busReq is high, so no snoop arrives during its own transaction. They also take the processor to hold cpuValid, cpuWrite, cpuAddr and cpuWdata steady until cpuReady, and busAck to come only while busReq is high. The bench issues every processor request and every snoop as a separate, non-overlapping operation. It acknowledges a transaction only after busReq has been seen, with a random delay of zero to two cycles. It keeps the request inputs fixed until completion. Random addresses are drawn from sixteen words over four lines, so tag conflicts, victim writebacks and snoop hits on every state occur often.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_READX = 2'd1,
    BC_WBACK = 2'd2
  } busCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       cpuStore;
    logic       fillLine;
    lineState_t fillState;
    logic       victimDrop;
    logic       snpUpdate;
    lineState_t snpNext;
  } dpStrobe_t;

endpackage

// File: rtl/mesi_line_dp.sv
module mesi_line_dp
  import mesi_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [TAG_W-1:0]   cpuTag,
  input  logic [INDEX_W-1:0] cpuIdx,
  input  logic [DATA_W-1:0]  cpuWdata,
  input  logic [TAG_W-1:0]   snpTag,
  input  logic [INDEX_W-1:0] snpIdx,
  input  logic [DATA_W-1:0]  busRdata,
  output logic               cpuHit,
  output lineState_t         idxState,
  output logic [TAG_W-1:0]   idxTag,
  output logic [DATA_W-1:0]  idxData,
  output lineState_t         snpState,
  output logic [DATA_W-1:0]  snpData
);

  localparam int LINES = 1 << INDEX_W;

  lineState_t          stV  [LINES];
  logic [TAG_W-1:0]    tagV [LINES];
  logic [DATA_W-1:0]   datV [LINES];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    lineState_t        stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] datQ;
    logic              selCpu;
    logic              selSnp;

    assign selCpu = (cpuIdx == INDEX_W'(g));
    assign selSnp = (snpIdx == INDEX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ  <= LS_INV;
        tagQ <= '0;
        datQ <= '0;
      end else begin
        if (strobe.snpUpdate && selSnp)        stQ <= strobe.snpNext;
        else if (strobe.fillLine && selCpu)    stQ <= strobe.fillState;
        else if (strobe.cpuStore && selCpu)    stQ <= LS_MOD;
        else if (strobe.victimDrop && selCpu)  stQ <= LS_INV;

        if (strobe.fillLine && selCpu) begin
          tagQ <= cpuTag;
          datQ <= busRdata;
        end else if (strobe.cpuStore && selCpu) begin
          datQ <= cpuWdata;
        end
      end
    end

    assign stV[g]  = stQ;
    assign tagV[g] = tagQ;
    assign datV[g] = datQ;
  end

  assign idxState = stV[cpuIdx];
  assign idxTag   = tagV[cpuIdx];
  assign idxData  = datV[cpuIdx];
  assign cpuHit   = (idxState != LS_INV) && (idxTag == cpuTag);

  assign snpState = ((stV[snpIdx] != LS_INV) && (tagV[snpIdx] == snpTag))
                    ? stV[snpIdx] : LS_INV;
  assign snpData  = datV[snpIdx];

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       cpuHit,
  input  lineState_t idxState,
  input  logic       snpValid,
  input  logic       snpCmd,
  input  lineState_t snpState,
  input  logic       busAck,
  input  logic       busShared,
  output logic       cpuReady,
  output logic       busReq,
  output busCmd_t    busCmd,
  output logic       useVictim,
  output logic       snpHit,
  output logic       snpWb,
  output dpStrobe_t  strobe
);

  typedef enum logic [1:0] {CS_IDLE, CS_WBACK, CS_FETCH} ctrlState_t;

  ctrlState_t stateQ, stateD;
  logic       snpMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= CS_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    cpuReady  = 1'b0;
    busReq    = 1'b0;
    busCmd    = BC_READ;
    useVictim = 1'b0;

    snpMatch  = snpValid && (snpState != LS_INV);
    snpHit    = snpMatch && !snpCmd;
    snpWb     = snpMatch && (snpState == LS_MOD);
    if (snpMatch) begin
      strobe.snpUpdate = 1'b1;
      strobe.snpNext   = snpCmd ? LS_INV : LS_SHR;
    end

    unique case (stateQ)
      CS_IDLE: begin
        if (cpuValid && !snpValid) begin
          if (cpuHit && (!cpuWrite || idxState == LS_EXC || idxState == LS_MOD)) begin
            cpuReady        = 1'b1;
            strobe.cpuStore = cpuWrite;
          end else if (cpuHit || idxState != LS_MOD) begin
            stateD = CS_FETCH;
          end else begin
            stateD = CS_WBACK;
          end
        end
      end
      CS_WBACK: begin
        busReq    = 1'b1;
        busCmd    = BC_WBACK;
        useVictim = 1'b1;
        if (busAck) begin
          strobe.victimDrop = 1'b1;
          stateD            = CS_FETCH;
        end
      end
      CS_FETCH: begin
        busReq = 1'b1;
        busCmd = cpuWrite ? BC_READX : BC_READ;
        if (busAck) begin
          strobe.fillLine  = 1'b1;
          strobe.fillState = cpuWrite ? LS_MOD : (busShared ? LS_SHR : LS_EXC);
          stateD           = CS_IDLE;
        end
      end
      default: stateD = CS_IDLE;
    endcase
  end

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic              snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic              snpWb,
  output logic [DATA_W-1:0] snpWbData
);

  localparam int TAG_W = ADDR_W - INDEX_W;

  dpStrobe_t          strobe;
  logic               cpuHit;
  lineState_t         idxState;
  lineState_t         snpState;
  logic [TAG_W-1:0]   idxTag;
  logic [DATA_W-1:0]  idxData;
  logic               useVictim;
  busCmd_t            cmd;
  logic [INDEX_W-1:0] cpuIdx;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];

  mesi_line_dp #(.TAG_W(TAG_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuTag   (cpuAddr[ADDR_W-1:INDEX_W]),
    .cpuIdx   (cpuIdx),
    .cpuWdata (cpuWdata),
    .snpTag   (snpAddr[ADDR_W-1:INDEX_W]),
    .snpIdx   (snpAddr[INDEX_W-1:0]),
    .busRdata (busRdata),
    .cpuHit   (cpuHit),
    .idxState (idxState),
    .idxTag   (idxTag),
    .idxData  (idxData),
    .snpState (snpState),
    .snpData  (snpWbData)
  );

  mesi_line_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuValid  (cpuValid),
    .cpuWrite  (cpuWrite),
    .cpuHit    (cpuHit),
    .idxState  (idxState),
    .snpValid  (snpValid),
    .snpCmd    (snpCmd),
    .snpState  (snpState),
    .busAck    (busAck),
    .busShared (busShared),
    .cpuReady  (cpuReady),
    .busReq    (busReq),
    .busCmd    (cmd),
    .useVictim (useVictim),
    .snpHit    (snpHit),
    .snpWb     (snpWb),
    .strobe    (strobe)
  );

  assign busCmd   = cmd;
  assign busAddr  = useVictim ? {idxTag, cpuIdx} : cpuAddr;
  assign busWdata = idxData;
  assign cpuRdata = idxData;

endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic              snpValid,
  input logic              snpCmd,
  input logic              snpHit,
  input logic              snpWb
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busCmd) && $stable(busAddr));

  // R11
  ready_nobus_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReq);

  // R10
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && busCmd == 2'd2 |=> busReq && busCmd != 2'd2);

  // R3
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && !cpuWrite && cpuReady |=> !busReq);

  // R8
  readx_nohit_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && snpCmd |-> !snpHit);

  // R9
  idle_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |-> !snpHit && !snpWb);

  // R6
  dirty_read_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && !snpCmd && snpWb |-> snpHit);

endmodule

bind mesi_snoop_cache mesi_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_mesi_snoop_cache.sv
`timescale 1ns/1ps
module test_mesi_snoop_cache;

  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuReady;
  logic [DW-1:0] cpuRdata;
  logic          busReq;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busAck = 1'b0;
  logic [DW-1:0] busRdata = '0;
  logic          busShared = 1'b0;
  logic          snpValid = 1'b0, snpCmd = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpHit, snpWb;
  logic [DW-1:0] snpWbData;

  always #2 clk = ~clk;

  mesi_snoop_cache #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW)) i_mesi_snoop_cache (.*);

  int checks = 0;
  int errors = 0;

  logic [1:0]      refSt   [NL];
  logic [AW-IW-1:0] refTag [NL];
  logic [DW-1:0]   refData [NL];
  logic [DW-1:0]   mem     [256];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic doCpu(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit sh);
    logic [IW-1:0]    ix;
    logic [AW-IW-1:0] tg;
    bit               hit, expWb, expFetch, done;
    logic [DW-1:0]    expData;
    string            rq;
    int               nTx;
    ix = a[IW-1:0];
    tg = a[AW-1:IW];
    hit = (refSt[ix] != 2'd0) && (refTag[ix] == tg);
    expWb = !hit && (refSt[ix] == 2'd3);
    expFetch = !(hit && (!wr || refSt[ix] >= 2'd2));
    rq = wr ? (expFetch ? "R4" : "R5") : (expFetch ? "R2" : "R3");
    expData = hit ? refData[ix] : mem[a];
    nTx = 0;
    done = 1'b0;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    for (int k = 0; k < 60 && !done; k++) begin
      #1;
      if (cpuReady) begin
        if (!wr) chk(cpuRdata == expData, rq, "read data", int'(cpuRdata), int'(expData));
        done = 1'b1;
      end else if (busReq) begin
        if (nTx == 0 && expWb) begin
          chk(busCmd == 2'd2, "R10", "victim cmd", int'(busCmd), 2);
          chk(busAddr == {refTag[ix], ix}, "R10", "victim addr", int'(busAddr), int'({refTag[ix], ix}));
          chk(busWdata == refData[ix], "R10", "victim data", int'(busWdata), int'(refData[ix]));
          mem[busAddr] = busWdata;
        end else begin
          chk(busCmd == (wr ? 2'd1 : 2'd0), rq, "fetch cmd", int'(busCmd), wr ? 1 : 0);
          chk(busAddr == a, rq, "fetch addr", int'(busAddr), int'(a));
        end
        nTx++;
        repeat ($urandom % 3) @(negedge clk);
        busAck = 1'b1; busRdata = mem[busAddr]; busShared = sh;
        @(negedge clk);
        busAck = 1'b0; busShared = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, rq, "request completed", int'(done), 1);
    chk(nTx == int'(expWb) + int'(expFetch), expWb ? "R10" : "R11",
        "bus transactions", nTx, int'(expWb) + int'(expFetch));
    @(negedge clk);
    cpuValid = 1'b0;
    if (expFetch) begin
      refTag[ix]  = tg;
      refData[ix] = mem[a];
      refSt[ix]   = wr ? 2'd3 : (sh ? 2'd1 : 2'd2);
    end
    if (wr) begin
      refData[ix] = d;
      refSt[ix]   = 2'd3;
    end
  endtask

  task automatic doSnoop(input bit x, input logic [AW-1:0] a);
    logic [IW-1:0] ix;
    bit            match, expHit, expWb;
    string         rq;
    ix = a[IW-1:0];
    match = (refSt[ix] != 2'd0) && (refTag[ix] == a[AW-1:IW]);
    expHit = match && !x;
    expWb = match && (refSt[ix] == 2'd3);
    rq = !match ? "R9" : (x ? "R8" : (refSt[ix] == 2'd3 ? "R6" : "R7"));
    @(negedge clk);
    snpValid = 1'b1; snpCmd = x; snpAddr = a;
    #1;
    chk(snpHit == expHit, rq, "snoop hit", int'(snpHit), int'(expHit));
    chk(snpWb == expWb, rq, "snoop writeback", int'(snpWb), int'(expWb));
    if (expWb) begin
      chk(snpWbData == refData[ix], rq, "writeback data", int'(snpWbData), int'(refData[ix]));
      mem[a] = snpWbData;
    end
    @(negedge clk);
    snpValid = 1'b0;
    if (match) refSt[ix] = x ? 2'd0 : 2'd1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 5);
    for (int i = 0; i < NL; i++) begin
      refSt[i] = 2'd0; refTag[i] = '0; refData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset outputs
    chk(!busReq && !cpuReady, "R1", "idle after reset", int'({busReq, cpuReady}), 0);
    for (int i = 0; i < NL; i++) begin
      @(negedge clk);
      snpValid = 1'b1; snpCmd = 1'b0; snpAddr = AW'(i);
      #1;
      chk(!snpHit && !snpWb, "R1", "no snoop response after reset", int'({snpHit, snpWb}), 0);
      @(negedge clk);
      snpValid = 1'b0;
    end

    // directed corner cases
    doCpu(1'b0, 8'h04, 16'h0, 1'b0);    // R2 fill Exclusive
    doCpu(1'b0, 8'h04, 16'h0, 1'b0);    // R3 hit
    doCpu(1'b1, 8'h04, 16'hA5A5, 1'b0); // R5 silent upgrade
    doSnoop(1'b0, 8'h04);               // R6 dirty read
    doCpu(1'b1, 8'h04, 16'h1234, 1'b0); // R4 Shared -> read-exclusive
    doSnoop(1'b1, 8'h04);               // R8 dirty read-exclusive
    doCpu(1'b0, 8'h04, 16'h0, 1'b1);    // R2 fill Shared
    doSnoop(1'b0, 8'h08);               // R9 tag mismatch
    doSnoop(1'b0, 8'h04);               // R7 shared hit
    doSnoop(1'b1, 8'h04);               // R8 clean invalidate
    doSnoop(1'b1, 8'h04);               // R9 invalid line
    doCpu(1'b1, 8'h04, 16'hBEEF, 1'b0); // R4 miss write
    doCpu(1'b1, 8'h04, 16'hCAFE, 1'b0); // R5 write Modified
    doCpu(1'b0, 8'h08, 16'h0, 1'b0);    // R10 dirty victim
    doCpu(1'b0, 8'h0C, 16'h0, 1'b1);    // R10 clean victim
    doCpu(1'b0, 8'h04, 16'h0, 1'b0);    // R2 memory holds written-back data

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [AW-1:0] a;
      r = int'($urandom % 10);
      a = AW'($urandom % 16);
      if (r < 6) doCpu(r[0], a, DW'($urandom), 1'($urandom % 2));
      else       doSnoop(1'($urandom % 2), a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule